// File: doc/BRIEF.md
# Character Line Repeat Vertical Scaler

This block is the per-scanline vertical sequencer of a character-cell overlay. It works at the pixel clock and is told of each new scanline by a one-cycle line strobe and of each vertical sync leading edge by a one-cycle frame strobe. After a programmable number of scanlines following the frame strobe, it walks the fifteen text rows. For every scanline it reports whether text is shown, which text row is current, and which of the eighteen glyph lines must be fetched from font storage.

Text rows are stretched vertically by emitting glyph lines more than once. A two-bit base field sets how many times every glyph line is emitted. Five weight bits add extra copies of fixed, evenly spread subsets of glyph lines. Each row may additionally be doubled. A programmable count of blank spacing scanlines follows every row. Once the last row and its spacing are done, the sequencer stays dark until the next frame strobe.

Top module: `ovl_vscaler`

## Requirements
- R1: After reset, and on any line strobe before the first frame strobe, `disp_active_o` is 0 and `row_o` and `line_o` read 0.
- R2: With delay code V, the first shown scanline (row 0, glyph line 0, active) appears on line strobe number 4*V+1 after the frame strobe, counting the first strobe after it as number 1; earlier strobes leave the outputs inactive.
- R3: Height code bits [6:5] set the base copy count m of every glyph line: 0 when 00 or 01 gives m=1, 10 gives m=2, 11 gives m=3.
- R4: Height code bits [3:0], when bit 4 is 0, each add one copy to a set of glyph lines. Bit 0 adds line 8. Bit 1 adds lines 4 and 12. Bit 2 adds lines 2, 6, 10 and 14. Bit 3 adds every odd line from 1 to 15.
- R5: When height code bits [4:0] equal 16, one copy is added to lines 1 to 16. When they are 17 or more, they act as 17 and one copy is added to lines 0 to 16.
- R6: Within a row, glyph lines 0 to 17 are emitted in ascending order, with each line's copies on consecutive scanlines, so a row lasts 18*m + L scanlines, where L is the clamped value of bits [4:0].
- R7: After each row, S = `spacing_i` (0 to 31) scanlines follow with `disp_active_o` 0, `line_o` 0 and `row_o` holding that row's index.
- R8: When bit r of `dbl_rows_i` is 1, every glyph line of row r is emitted twice as many times; spacing is not doubled.
- R9: After row 14 and its spacing, the outputs read inactive with row 0 and line 0, and further line strobes change nothing until a frame strobe.
- R10: A frame strobe restarts the sequence at any point: the outputs go inactive at the next clock edge and the delay count starts over. A line strobe in the same cycle as a frame strobe is not counted.
- R11: The outputs change only at clock edges where a line strobe or frame strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb_i | input | 1 | One-cycle pulse per scanline |
| frame_stb_i | input | 1 | One-cycle pulse at vertical sync leading edge |
| vdelay_i | input | 8 | Start delay code, steps of four scanlines |
| height_i | input | 7 | Character height code: base field [6:5], weights [4:0] |
| spacing_i | input | 5 | Blank scanlines after each row |
| dbl_rows_i | input | 15 | Per-row double-height enables, bit r for row r |
| disp_active_o | output | 1 | Current scanline shows text |
| row_o | output | 4 | Current text row index |
| line_o | output | 5 | Glyph line to fetch |

## Verification
Several checks run on every cycle. The outputs hold steady without a strobe, and the indices stay within 15 rows and 18 glyph lines. Inside a row, the glyph line only ever steps up by one. A frame strobe always darkens the display on the next edge, and display starts only on a line strobe. The things that need whole scenarios are the bench's work: the exact strobe on which display starts, how many copies each height code gives each glyph line, the length of the spacing gap, the effect of the per-row doubling, and the quiet period after the last row. The bench sweeps all 128 height codes and several full frames, comparing every scanline against an arithmetic model.

// File: rtl/ovl_vscaler_pkg.sv
package ovl_vscaler_pkg;
  localparam int GLYPH_LINES = 18;
  localparam int LINE_W      = $clog2(GLYPH_LINES);
  localparam int HCODE_W     = 7;
  // largest copy count: base 3 + one weight copy, doubled = 8
  localparam int REP_W       = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SHOW = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ovl_vs_delay.sv
module ovl_vs_delay #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb_i,
  input  logic               line_stb_i,
  input  logic [DELAY_W-1:0] vdelay_i,
  output logic               start_o
);
  localparam int CNT_W = DELAY_W + 2;

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_inc;
  logic             upd_en;

  assign target  = {vdelay_i, 2'b00} + CNT_W'(1);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign start_o = armed_q & line_stb_i & ~frame_stb_i & (cnt_inc == target);
  assign upd_en  = frame_stb_i | line_stb_i;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (frame_stb_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (line_stb_i && armed_q) begin
      if (start_o) armed_d = 1'b0;
      else         cnt_d   = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/ovl_vs_repeat.sv
module ovl_vs_repeat
  import ovl_vscaler_pkg::*;
(
  input  logic [LINE_W-1:0]  line_i,
  input  logic [HCODE_W-1:0] code_i,
  input  logic               dbl_i,
  output logic [REP_W-1:0]   need_o
);
  localparam logic [4:0] WEIGHT_CAP = 5'd17;

  logic [1:0] base_mult;
  logic [4:0] low_w;
  logic       extra;
  logic [2:0] single;

  always_comb begin
    unique case (code_i[6:5])
      2'b11:   base_mult = 2'd3;
      2'b10:   base_mult = 2'd2;
      default: base_mult = 2'd1;
    endcase
  end

  assign low_w = (code_i[4:0] > WEIGHT_CAP) ? WEIGHT_CAP : code_i[4:0];

  always_comb begin
    if (low_w == 5'd17) begin
      extra = (line_i <= LINE_W'(16));
    end else if (low_w == 5'd16) begin
      extra = (line_i >= LINE_W'(1)) && (line_i <= LINE_W'(16));
    end else begin
      extra = (low_w[0] && (line_i == LINE_W'(8)))
            | (low_w[1] && ((line_i == LINE_W'(4)) || (line_i == LINE_W'(12))))
            | (low_w[2] && (line_i[1:0] == 2'b10) && (line_i <= LINE_W'(14)))
            | (low_w[3] && line_i[0] && (line_i <= LINE_W'(15)));
    end
  end

  assign single = {1'b0, base_mult} + {2'b00, extra};
  assign need_o = dbl_i ? {single, 1'b0} : {1'b0, single};
endmodule

// File: rtl/ovl_vs_seq.sv
module ovl_vs_seq
  import ovl_vscaler_pkg::*;
#(
  parameter int ROWS    = 15,
  parameter int SPACE_W = 5,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb_i,
  input  logic               line_stb_i,
  input  logic               start_i,
  input  logic [SPACE_W-1:0] spacing_i,
  input  logic [ROWS-1:0]    dbl_rows_i,
  input  logic [REP_W-1:0]   need_i,
  output logic               dbl_o,
  output logic               active_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [LINE_W-1:0]  line_o
);
  seq_state_e         state_q, state_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [LINE_W-1:0]  line_q, line_d;
  logic [REP_W-1:0]   rep_q, rep_d;
  logic [SPACE_W-1:0] gap_q, gap_d;
  logic [REP_W-1:0]   rep_inc;
  logic [SPACE_W-1:0] gap_inc;
  logic               last_row;
  logic               advance;
  logic               upd_en;

  assign rep_inc  = rep_q + REP_W'(1);
  assign gap_inc  = gap_q + SPACE_W'(1);
  assign last_row = (row_q == ROW_W'(ROWS - 1));
  assign upd_en   = frame_stb_i | line_stb_i;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    line_d  = line_q;
    rep_d   = rep_q;
    gap_d   = gap_q;
    advance = 1'b0;
    if (frame_stb_i) begin
      state_d = SEQ_IDLE;
      row_d   = '0;
      line_d  = '0;
      rep_d   = '0;
      gap_d   = '0;
    end else if (line_stb_i) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_d = SEQ_SHOW;
            row_d   = '0;
            line_d  = '0;
            rep_d   = '0;
          end
        end
        SEQ_SHOW: begin
          if (rep_inc < need_i) begin
            rep_d = rep_inc;
          end else begin
            rep_d = '0;
            if (line_q != LINE_W'(GLYPH_LINES - 1)) begin
              line_d = line_q + LINE_W'(1);
            end else begin
              line_d = '0;
              if (spacing_i != '0) begin
                state_d = SEQ_GAP;
                gap_d   = '0;
              end else begin
                advance = 1'b1;
              end
            end
          end
        end
        SEQ_GAP: begin
          if (gap_inc < spacing_i) gap_d   = gap_inc;
          else                     advance = 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
      if (advance) begin
        line_d = '0;
        rep_d  = '0;
        gap_d  = '0;
        if (last_row) begin
          state_d = SEQ_IDLE;
          row_d   = '0;
        end else begin
          state_d = SEQ_SHOW;
          row_d   = row_q + ROW_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      row_q   <= '0;
      line_q  <= '0;
      rep_q   <= '0;
      gap_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      row_q   <= row_d;
      line_q  <= line_d;
      rep_q   <= rep_d;
      gap_q   <= gap_d;
    end
  end

  assign dbl_o    = dbl_rows_i[row_q];
  assign active_o = (state_q == SEQ_SHOW);
  assign row_o    = row_q;
  assign line_o   = line_q;
endmodule

// File: rtl/ovl_vscaler.sv
module ovl_vscaler
  import ovl_vscaler_pkg::*;
#(
  parameter int ROWS    = 15,
  parameter int DELAY_W = 8,
  parameter int SPACE_W = 5,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_stb_i,
  input  logic               frame_stb_i,
  input  logic [DELAY_W-1:0] vdelay_i,
  input  logic [HCODE_W-1:0] height_i,
  input  logic [SPACE_W-1:0] spacing_i,
  input  logic [ROWS-1:0]    dbl_rows_i,
  output logic               disp_active_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [LINE_W-1:0]  line_o
);
  logic             start;
  logic             row_dbl;
  logic [REP_W-1:0] need;

  ovl_vs_delay #(.DELAY_W(DELAY_W)) u_delay (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb_i (frame_stb_i),
    .line_stb_i  (line_stb_i),
    .vdelay_i    (vdelay_i),
    .start_o     (start)
  );

  ovl_vs_repeat u_repeat (
    .line_i (line_o),
    .code_i (height_i),
    .dbl_i  (row_dbl),
    .need_o (need)
  );

  ovl_vs_seq #(.ROWS(ROWS), .SPACE_W(SPACE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb_i (frame_stb_i),
    .line_stb_i  (line_stb_i),
    .start_i     (start),
    .spacing_i   (spacing_i),
    .dbl_rows_i  (dbl_rows_i),
    .need_i      (need),
    .dbl_o       (row_dbl),
    .active_o    (disp_active_o),
    .row_o       (row_o),
    .line_o      (line_o)
  );
endmodule

// File: rtl/ovl_vscaler_chk.sv
module ovl_vscaler_chk
  import ovl_vscaler_pkg::*;
#(
  parameter int ROWS    = 15,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_stb_i,
  input logic              frame_stb_i,
  input logic              disp_active_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [LINE_W-1:0] line_o
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb_i && !frame_stb_i) |=>
      ($stable(disp_active_o) && $stable(row_o) && $stable(line_o)));

  assert_frame_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |=> (!disp_active_o && row_o == '0 && line_o == '0));

  assert_start_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_active_o) |-> $past(line_stb_i));

  assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_o < LINE_W'(GLYPH_LINES));

  assert_row_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_o < ROW_W'(ROWS));

  assert_line_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_active_o && $past(disp_active_o) && row_o == $past(row_o)
      && line_o != $past(line_o)) |-> (line_o == LINE_W'($past(line_o) + 1)));

  assert_gap_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_active_o |-> (line_o == '0));
endmodule

bind ovl_vscaler ovl_vscaler_chk #(.ROWS(ROWS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_stb_i    (line_stb_i),
  .frame_stb_i   (frame_stb_i),
  .disp_active_o (disp_active_o),
  .row_o         (row_o),
  .line_o        (line_o)
);

// File: tb/ovl_vscaler_test.sv
module ovl_vscaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NROWS      = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_stb;
  logic        frame_stb;
  logic [7:0]  vdelay;
  logic [6:0]  height;
  logic [4:0]  spacing;
  logic [14:0] dbl_rows;
  logic        disp_active;
  logic [3:0]  row;
  logic [4:0]  line;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovl_vscaler uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_stb_i    (line_stb),
    .frame_stb_i   (frame_stb),
    .vdelay_i      (vdelay),
    .height_i      (height),
    .spacing_i     (spacing),
    .dbl_rows_i    (dbl_rows),
    .disp_active_o (disp_active),
    .row_o         (row),
    .line_o        (line)
  );

  // copies of glyph line g, from the height code rules
  function automatic int glyph_reps(int g, int code, bit dbl);
    int m, low, ex;
    m = (code >= 96) ? 3 : ((code >= 64) ? 2 : 1);
    low = code % 32;
    if (low > 17) low = 17;
    ex = 0;
    if (low == 17)      ex = (g <= 16) ? 1 : 0;
    else if (low == 16) ex = (g >= 1 && g <= 16) ? 1 : 0;
    else begin
      if ((low % 2) == 1 && g == 8) ex = 1;
      if (((low / 2) % 2) == 1 && (g == 4 || g == 12)) ex = 1;
      if (((low / 4) % 2) == 1 && (g % 4) == 2 && g < 15) ex = 1;
      if ((low / 8) == 1 && (g % 2) == 1 && g < 16) ex = 1;
    end
    return dbl ? 2 * (m + ex) : (m + ex);
  endfunction

  function automatic int frame_total(int v, int code, int s, logic [14:0] dbl);
    int t;
    t = 4 * v + 1;
    for (int r = 0; r < NROWS; r++) begin
      for (int g = 0; g < 18; g++) t += glyph_reps(g, code, dbl[r]);
      t += s;
    end
    return t;
  endfunction

  // expected {active,row,line} after line strobe k (1-based) of a frame
  function automatic logic [9:0] expect_at(int k, int v, int code, int s,
                                           logic [14:0] dbl);
    int t, c;
    t = k - (4 * v + 1);
    if (t < 0) return 10'd0;
    for (int r = 0; r < NROWS; r++) begin
      for (int g = 0; g < 18; g++) begin
        c = glyph_reps(g, code, dbl[r]);
        if (t < c) return {1'b1, 4'(r), 5'(g)};
        t -= c;
      end
      if (t < s) return {1'b0, 4'(r), 5'd0};
      t -= s;
    end
    return 10'd0;
  endfunction

  task automatic check(logic [9:0] e, string tag);
    vectors++;
    if ({disp_active, row, line} !== e) begin
      miscompares++;
      $display("FAIL %s: active/row/line = %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, disp_active, row, line, e[9], e[8:5], e[4:0]);
    end
  endtask

  task automatic pulse_line();
    @(negedge clk) line_stb = 1'b1;
    @(negedge clk) line_stb = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_stb = 1'b1;
    @(negedge clk) frame_stb = 1'b0;
  endtask

  task automatic run_frame(int v, int code, int s, logic [14:0] dbl,
                           int nlines, string tag);
    vdelay = 8'(v); height = 7'(code); spacing = 5'(s); dbl_rows = dbl;
    pulse_frame();
    check(10'd0, "R10");
    for (int k = 1; k <= nlines; k++) begin
      pulse_line();
      check(expect_at(k, v, code, s, dbl), tag);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    string tag;
    int lw;
    rst_n = 1'b0; line_stb = 1'b0; frame_stb = 1'b0;
    vdelay = '0; height = '0; spacing = '0; dbl_rows = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(10'd0, "R1");
    // R1: strobes before any frame strobe do nothing
    for (int i = 0; i < 3; i++) begin
      pulse_line();
      check(10'd0, "R1");
    end

    // R3 R4 R5 R6: every height code, first row plus start of row 1
    for (int code = 0; code < 128; code++) begin
      lw = code % 32;
      tag = (lw >= 16) ? "R5" : ((lw != 0) ? "R4" : "R3");
      run_frame(0, code, 0, 15'd0, frame_total(0, code, 0, 15'd0) / NROWS + 1, tag);
    end

    // R2: longest start delay, whole frame
    run_frame(255, 0, 0, 15'd0, frame_total(255, 0, 0, 15'd0) + 2, "R2");
    // R7: spacing extremes
    run_frame(0, 7'h11, 31, 15'd0, frame_total(0, 7'h11, 31, 15'd0), "R7");
    run_frame(1, 7'h2A, 1, 15'd0, frame_total(1, 7'h2A, 1, 15'd0), "R7");
    // R8: alternate and all rows doubled
    run_frame(3, 7'h40, 2, 15'h5555, frame_total(3, 7'h40, 2, 15'h5555), "R8");
    run_frame(2, 7'h7F, 1, 15'h7FFF, frame_total(2, 7'h7F, 1, 15'h7FFF), "R8");
    // R9: strobes after the last row leave the display dark
    run_frame(0, 7'h05, 3, 15'h0001, frame_total(0, 7'h05, 3, 15'h0001) + 8, "R9");

    // R10: restart in the middle of the display
    run_frame(1, 7'h03, 0, 15'd0, 40, "R10");
    run_frame(2, 7'h21, 4, 15'h0002, 60, "R10");

    // R10: line strobe coincident with frame strobe is not counted
    vdelay = 8'd1; height = 7'd0; spacing = 5'd0; dbl_rows = 15'd0;
    @(negedge clk) begin frame_stb = 1'b1; line_stb = 1'b1; end
    @(negedge clk) begin frame_stb = 1'b0; line_stb = 1'b0; end
    check(10'd0, "R10");
    for (int k = 1; k <= 7; k++) begin
      pulse_line();
      check(expect_at(k, 1, 0, 0, 15'd0), "R10");
    end

    // R11: outputs hold between strobes
    repeat (4) @(negedge clk);
    check(expect_at(7, 1, 0, 0, 15'd0), "R11");
    pulse_frame();
    repeat (5) @(negedge clk);
    check(10'd0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule